// File: doc/BRIEF.md
# Serial DAC Update Writer

This block is a two-wire bus master with one job: pushing a new 8-bit code into a small serial DAC. A one-cycle load strobe carries the new code. The block then builds a fixed write frame and clocks it out on the open-drain clock and data lines. The frame holds a start condition, a slave address byte, a constant command byte that selects output channel 0, the data byte, and a stop condition. After every byte the master releases the data line for one bit time and samples the slave's acknowledge.

The two low address bits come from strap inputs, so one design can talk to any of four strapped slaves. The block never drives a line high. It only pulls a line low through an output enable, and the pull-ups on the board return the line high. A refused acknowledge ends the frame early and raises an error flag. A done pulse marks the end of every frame, whether it completed or was aborted. The bus clock comes from the system clock through a divider, so the same design runs at the 400 kHz fast-mode rate from any suitable system clock.

Top module: `dac_link_writer`

## Requirements
- R1: The first byte on the wire is {5'b01011, strap_i[1], strap_i[0], 1'b0} (0x58 with both straps low). The straps are sampled on the accepted load strobe.
- R2: The second byte on the wire is the command 0x00.
- R3: The third byte is the loaded value. All bytes go out most significant bit first.
- R4: Each frame is one start condition, then bytes of eight data clocks plus one acknowledge clock each, then one stop condition.
- R5: Inside a frame the data line changes only while the clock line is low. The two exceptions are the start (data falls while the clock is high) and the stop (data rises while the clock is high).
- R6: The bus clock period is 4*floor(CLK_HZ/(4*BUS_HZ)) system clocks. This is 124 clocks (2.48 us) at 50 MHz and 400 kHz.
- R7: If the data line is high in an acknowledge slot, nack_err_o is set. The stop follows that slot at once, and no further byte is sent.
- R8: busy_o rises the cycle after an accepted load and stays high until the stop is complete. A load strobe while busy_o is high is ignored.
- R9: done_o is a single-cycle pulse in the first cycle that busy_o is low after a frame.
- R10: Under reset, both output enables, busy_o, done_o and nack_err_o are low, and an open frame is abandoned.
- R11: nack_err_o is cleared when a new load is accepted, so a fully acknowledged frame leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | One-cycle request to send a new code |
| value_i | input | 8 | DAC code to send |
| strap_i | input | 2 | Strapped low address bits |
| sda_i | input | 1 | Sensed level of the data line |
| scl_oe_o | output | 1 | 1 pulls the clock line low |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | Frame finished pulse |
| nack_err_o | output | 1 | Last frame was refused |

## Verification
Most internal faults show at the pins within one bus bit time (124 clocks). A wrong bit counter or byte index gives a byte with the wrong length or content, which a decoder on the bus sees at the next acknowledge slot. A wrong phase or quarter decode moves a data edge into a clock-high window, which appears as an extra start or stop straight away. A broken acknowledge sample shows as a frame that runs past the refused byte, or stops after an accepted one, with nack_err_o wrong at done_o. A stuck phase register shows as done_o never arriving.

// File: rtl/dlw_pkg.sv
// Shared types for the DAC update writer.
// Assumes: a frame is a start, whole 9-clock byte slots, and a stop.
package dlw_pkg;
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_START,
        PH_SLOT,
        PH_STOP
    } phase_t;

    localparam int SLOT_BITS = 9;
    localparam int BYTE_BITS = 8;
endpackage

// File: rtl/dlw_tick.sv
// Quarter-bit strobe generator.
// Makes a one-cycle tick every QTR clocks while run is high. It restarts
// from zero whenever run is low, so the first quarter of a frame is full length.
// Assumes QTR >= 2.
module dlw_tick #(
    parameter int QTR = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;

    logic [CW-1:0] cnt;

    // Count system clocks within one quarter of a bus bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(QTR - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // Ticks are isolated pulses, never back to back (R6).
    assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/dlw_frame.sv
// Byte selector for the three-byte write frame.
// Index 0 is the address with the write bit, index 1 is the command byte,
// and index 2 is the DAC code. Purely combinational.
module dlw_frame #(
    parameter logic [4:0] ADDR_HI  = 5'b01011,
    parameter logic [7:0] CMD_BYTE = 8'h00,
    parameter int         IDX_W    = 2
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       strap,
    input  logic [7:0]       value,
    output logic [7:0]       byte_o
);
    // Pick the byte for the current slot index.
    always_comb begin
        case (idx)
            IDX_W'(0): byte_o = {ADDR_HI, strap, 1'b0};
            IDX_W'(1): byte_o = CMD_BYTE;
            default:   byte_o = value;
        endcase
    end
endmodule

// File: rtl/dlw_seq.sv
// Frame sequencer. Steps start, byte slots and stop in quarter-bit phases:
//   slot: q0 clock low (data held), q1 data set, q2/q3 clock high.
//   start: data falls in q1 while the clock is high; the clock falls in q3.
//   stop: data pulled low in q1, clock rises in q2, data released in q3.
// The pin enables are registered one cycle behind the phase decode.
// The data line input is synchronised before the acknowledge sample.
module dlw_seq
    import dlw_pkg::*;
#(
    parameter int BYTES = 3,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic [7:0]       cur_byte,
    input  logic             sda_in,
    output logic [IDX_W-1:0] byte_idx,
    output logic             accept,
    output logic             busy,
    output logic             done,
    output logic             nack_err,
    output logic             scl_oe,
    output logic             sda_oe
);
    phase_t     ph;
    logic [1:0] qtr;
    logic [3:0] bit_idx;
    logic       sda_s1, sda_s2;
    logic       scl_nx, sda_nx, bitv;
    logic [2:0] pos;

    assign busy   = (ph != PH_IDLE);
    assign accept = load && (ph == PH_IDLE);

    // Two-flop synchroniser for the sensed data line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_s1 <= 1'b1;
            sda_s2 <= 1'b1;
        end else begin
            sda_s1 <= sda_in;
            sda_s2 <= sda_s1;
        end
    end

    // Bit value for the current slot; the acknowledge slot releases the line.
    always_comb begin
        pos  = 3'd7 - bit_idx[2:0];
        bitv = (bit_idx == 4'(BYTE_BITS)) ? 1'b1 : cur_byte[pos];
    end

    // Pin enable decode for the current phase and quarter.
    always_comb begin
        case (ph)
            PH_START: begin
                scl_nx = (qtr == 2'd3);
                sda_nx = (qtr != 2'd0);
            end
            PH_SLOT: begin
                scl_nx = !qtr[1];
                sda_nx = (qtr == 2'd0) ? sda_oe : !bitv;
            end
            PH_STOP: begin
                scl_nx = !qtr[1];
                sda_nx = (qtr == 2'd0) ? sda_oe : (qtr != 2'd3);
            end
            default: begin
                scl_nx = 1'b0;
                sda_nx = 1'b0;
            end
        endcase
    end

    // Phase, slot and byte stepping, acknowledge sampling and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= PH_IDLE;
            qtr      <= 2'd0;
            bit_idx  <= 4'd0;
            byte_idx <= '0;
            done     <= 1'b0;
            nack_err <= 1'b0;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            done   <= 1'b0;
            scl_oe <= scl_nx;
            sda_oe <= sda_nx;
            if (ph == PH_IDLE) begin
                if (load) begin
                    ph       <= PH_START;
                    qtr      <= 2'd0;
                    bit_idx  <= 4'd0;
                    byte_idx <= '0;
                    nack_err <= 1'b0;
                end
            end else if (tick) begin
                qtr <= qtr + 2'd1;
                if (ph == PH_SLOT && bit_idx == 4'(BYTE_BITS) && qtr == 2'd2)
                    nack_err <= sda_s2;
                if (qtr == 2'd3) begin
                    case (ph)
                        PH_START: begin
                            ph      <= PH_SLOT;
                            bit_idx <= 4'd0;
                        end
                        PH_SLOT: begin
                            if (bit_idx == 4'(SLOT_BITS - 1)) begin
                                bit_idx <= 4'd0;
                                if (nack_err || byte_idx == IDX_W'(BYTES - 1))
                                    ph <= PH_STOP;
                                else
                                    byte_idx <= byte_idx + 1'b1;
                            end else begin
                                bit_idx <= bit_idx + 4'd1;
                            end
                        end
                        default: begin
                            ph   <= PH_IDLE;
                            done <= 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    // Data moves inside byte slots only while the clock is held low (R5).
    assert_sda_clock_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_SLOT && !$stable(sda_oe)) |-> (scl_oe && $past(scl_oe)));

    // A refused acknowledge sends the sequencer straight to stop (R7).
    assert_nack_to_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_SLOT && bit_idx == 4'(BYTE_BITS) && qtr == 2'd3 && tick && nack_err)
        |=> (ph == PH_STOP));

    // done is a lone pulse (R9).
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // done arrives as busy falls (R9).
    assert_done_at_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
endmodule

// File: rtl/dac_link_writer.sv
// Top of the DAC update writer. Latches the code and straps on an accepted
// load and feeds the frame selector and the sequencer. The lines are
// open-drain: an enable of 1 pulls the line low.
// Assumes the pull-ups are external and no slave stretches the clock.
module dac_link_writer #(
    parameter int         CLK_HZ   = 50_000_000,
    parameter int         BUS_HZ   = 400_000,
    parameter logic [4:0] ADDR_HI  = 5'b01011,
    parameter logic [7:0] CMD_BYTE = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [7:0] value_i,
    input  logic [1:0] strap_i,
    input  logic       sda_i,
    output logic       scl_oe_o,
    output logic       sda_oe_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       nack_err_o
);
    localparam int QTR   = CLK_HZ / (4 * BUS_HZ);
    localparam int BYTES = 3;
    localparam int IDX_W = $clog2(BYTES);

    logic [7:0]       val_q;
    logic [1:0]       strap_q;
    logic [7:0]       cur_byte;
    logic [IDX_W-1:0] byte_idx;
    logic             tick, accept;

    // Capture the code and straps on an accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q   <= 8'h00;
            strap_q <= 2'b00;
        end else if (accept) begin
            val_q   <= value_i;
            strap_q <= strap_i;
        end
    end

    dlw_tick #(.QTR(QTR)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_o),
        .tick  (tick)
    );

    dlw_frame #(.ADDR_HI(ADDR_HI), .CMD_BYTE(CMD_BYTE), .IDX_W(IDX_W)) u_frame (
        .idx    (byte_idx),
        .strap  (strap_q),
        .value  (val_q),
        .byte_o (cur_byte)
    );

    dlw_seq #(.BYTES(BYTES), .IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_i),
        .tick     (tick),
        .cur_byte (cur_byte),
        .sda_in   (sda_i),
        .byte_idx (byte_idx),
        .accept   (accept),
        .busy     (busy_o),
        .done     (done_o),
        .nack_err (nack_err_o),
        .scl_oe   (scl_oe_o),
        .sda_oe   (sda_oe_o)
    );

    // A load while busy leaves the latched frame contents untouched (R8).
    assert_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && load_i) |=> ($stable(val_q) && $stable(strap_q)));
endmodule

// File: tb/sim_dac_link_writer.sv
// Bench: a bus decoder and acknowledging slave on the two lines, a vector
// table walked by one loop, then directed reset and busy-load cases.
module sim_dac_link_writer;
    localparam int CLK_HZ = 50_000_000;
    localparam int BUS_HZ = 400_000;
    localparam int CLK_NS = 20;
    localparam int PER_NS = 4 * (CLK_HZ / (4 * BUS_HZ)) * CLK_NS;

    // {value[7:0], strap[1:0], refused byte index (3 = none)}
    localparam logic [11:0] VEC [0:7] = '{
        12'hA53, 12'h3C7, 12'hFFB, 12'h00F,
        12'h810, 12'h7ED, 12'h5A7, 12'h96A
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic [7:0] value = 8'h00;
    logic [1:0] strap = 2'b00;
    logic       scl_oe, sda_oe, busy, done, nack_err;
    logic       slave_low = 1'b0;
    logic       scl_line, sda_line;

    assign scl_line = !scl_oe;
    assign sda_line = !sda_oe && !slave_low;

    int errors = 0;
    int checks = 0;

    int         starts, stops, nbytes, bitcnt, nack_byte;
    logic [7:0] got [0:3];
    logic [7:0] shift;
    bit         in_frame, busy_at_stop;
    time        last_rise, per_min, per_max;

    dac_link_writer #(.CLK_HZ(CLK_HZ), .BUS_HZ(BUS_HZ)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .value_i    (value),
        .strap_i    (strap),
        .sda_i      (sda_line),
        .scl_oe_o   (scl_oe),
        .sda_oe_o   (sda_oe),
        .busy_o     (busy),
        .done_o     (done),
        .nack_err_o (nack_err)
    );

    always #(CLK_NS / 2) clk = !clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Bus decoder and slave model: tracks start/stop, bytes, clock period, acks.
    initial begin
        bit ps, pd;
        ps = 1'b1; pd = 1'b1;
        forever begin
            @(scl_line or sda_line);
            if (scl_line && ps && pd && !sda_line) begin
                starts++; in_frame = 1'b1; bitcnt = 0; shift = 8'h00; last_rise = 0;
            end else if (scl_line && ps && !pd && sda_line) begin
                stops++; in_frame = 1'b0; busy_at_stop = busy;
            end
            if (!ps && scl_line && in_frame) begin
                if (last_rise != 0) begin
                    if ($time - last_rise < per_min) per_min = $time - last_rise;
                    if ($time - last_rise > per_max) per_max = $time - last_rise;
                end
                last_rise = $time;
                if (bitcnt < 8) shift = {shift[6:0], sda_line};
                bitcnt++;
                if (bitcnt == 9) begin
                    if (nbytes < 4) got[nbytes] = shift;
                    nbytes++; bitcnt = 0;
                end
            end
            if (ps && !scl_line && in_frame)
                slave_low = (bitcnt == 8) && (nbytes != nack_byte);
            ps = scl_line; pd = sda_line;
        end
    end

    task automatic clear_mon(input int nb);
        slave_low = 1'b0;
        @(negedge clk);
        @(negedge clk);
        starts = 0; stops = 0; nbytes = 0; bitcnt = 0; in_frame = 1'b0;
        busy_at_stop = 1'b0; last_rise = 0; per_min = 64'd1 << 40; per_max = 0;
        nack_byte = nb;
        for (int i = 0; i < 4; i++) got[i] = 8'h00;
    endtask

    task automatic do_load(input logic [7:0] v, input logic [1:0] s);
        @(negedge clk);
        value = v; strap = s; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        chk(busy == 1'b1, "R8 busy after load", int'(busy), 1);
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, "R9 watchdog waiting for done", int'(done), 1);
        chk(busy == 1'b0, "R9 busy low with done", int'(busy), 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
    endtask

    task automatic verify(input logic [7:0] v, input logic [1:0] s, input int nb);
        int exp_n;
        exp_n = (nb == 3) ? 3 : nb + 1;
        chk(starts == 1, "R4 one start", starts, 1);
        chk(stops == 1, "R5 one stop, no stray edges", stops, 1);
        chk(nbytes == exp_n, "R7 byte count", nbytes, exp_n);
        chk(got[0] == {5'b01011, s, 1'b0}, "R1 address byte", int'(got[0]),
            int'({5'b01011, s, 1'b0}));
        if (exp_n > 1) chk(got[1] == 8'h00, "R2 command byte", int'(got[1]), 0);
        if (exp_n > 2) chk(got[2] == v, "R3 data byte", int'(got[2]), int'(v));
        chk(nack_err == (nb != 3), "R7 R11 nack flag", int'(nack_err), int'(nb != 3));
        chk(busy_at_stop == 1'b1, "R8 busy through stop", int'(busy_at_stop), 1);
    endtask

    initial begin
        #(200000 * CLK_NS);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clear_mon(3);
        repeat (3) @(negedge clk);
        // R10: reset state
        chk({scl_oe, sda_oe, busy, done, nack_err} == 5'b0, "R10 reset outputs",
            int'({scl_oe, sda_oe, busy, done, nack_err}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int k = 0; k < 8; k++) begin
            clear_mon(int'(VEC[k][1:0]));
            do_load(VEC[k][11:4], VEC[k][3:2]);
            wait_done();
            verify(VEC[k][11:4], VEC[k][3:2], int'(VEC[k][1:0]));
            if (k == 0) begin
                chk(per_min == PER_NS, "R6 clock period min", int'(per_min), PER_NS);
                chk(per_max == PER_NS, "R6 clock period max", int'(per_max), PER_NS);
            end
        end

        // R10: idle reset clears the refusal flag left by the last vector
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(nack_err == 1'b0, "R10 reset clears nack", int'(nack_err), 0);
        rst_n = 1'b1;

        // R8: a load during a frame is ignored
        clear_mon(3);
        do_load(8'h11, 2'b00);
        repeat (500) @(negedge clk);
        value = 8'hEE; strap = 2'b11; load = 1'b1;
        @(negedge clk); load = 1'b0;
        wait_done();
        verify(8'h11, 2'b00, 3);
        repeat (300) @(negedge clk);
        chk(busy == 1'b0 && starts == 1, "R8 ignored load starts nothing", starts, 1);

        // R10: reset in mid frame abandons it, then a fresh frame works
        clear_mon(3);
        do_load(8'h42, 2'b01);
        repeat (1000) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({scl_oe, sda_oe, busy} == 3'b0, "R10 mid-frame reset releases lines",
            int'({scl_oe, sda_oe, busy}), 0);
        rst_n = 1'b1;
        clear_mon(3);
        do_load(8'hC3, 2'b10);
        wait_done();
        verify(8'hC3, 2'b10, 3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule